// File: doc/BRIEF.md
# Locked Watchdog Configuration Port

This block is a countdown watchdog whose settings sit behind an index/data register pair. A host reaches it through two byte-wide I/O locations. The index location (0x2E on the host bus, `portSel` = 0 here) names a register, and the data location (0x2F, `portSel` = 1) reads or writes that register. Host bus decoding is outside the block, so the two locations arrive already split by `portSel`.

The configuration space starts closed. Software opens it by writing the key byte twice in a row to the index location. It then selects a logical page through a page register. Only the watchdog page exposes the enable bit, the time unit, the 8-bit countdown and the choice of peripheral interrupts that restart the countdown. A single close byte written to the index location shuts the space again.

Time is counted from a one-cycle `tickEn` strobe, which the system supplies once per second. In minute mode the block divides that strobe internally. On expiry the block drives a reset pulse of fixed length and then holds still until software reprograms it.

Top module: `wdt_cfg_port`

## Requirements
- R1: After reset the space is closed, data-port reads return 0xFF, `wdtRst` is low, and the enable, unit, timer, interrupt-source and page registers are all zero.
- R2: The space opens only after two consecutive index writes of 0x87. Any other index value while closed, or between the two key writes, leaves it closed. While closed, data reads return 0xFF and data writes change nothing.
- R3: An index write of 0xAA while open closes the space. Data reads then return 0xFF and data writes are dropped. The selected index survives relocking.
- R4: Index 0x07 is the page register, and it reads back what was written. Only with page 0x08 are indexes 0x30, 0xF5, 0xF6 and 0xF7 reachable. With any other page, or any other index, reads give 0xFF and writes are dropped.
- R5: Register 0x30 bit 0 is the run enable, and it reads back with the other bits zero. While it is 0 the countdown does not move.
- R6: A write to register 0xF6 loads both the countdown and its reload value. Reading 0xF6 returns the live count.
- R7: Register 0xF5 bit 3 picks the unit, and it reads back with the other bits zero. With 0, each `tickEn` lowers the count by one. With 1, every MIN_TICKS-th `tickEn` does.
- R8: In register 0xF7, bit 6 lets `kbdIrq` restore the count to the last value written to 0xF6, and bit 7 does the same for `mouseIrq`. Each bit reads back in its own position, with the other bits zero. An interrupt whose bit is clear has no effect.
- R9: A unit step taken with a count of 1 or 0 sets the count to 0. `wdtRst` then goes high from the next cycle for exactly RST_PULSE cycles.
- R10: After expiry the count stays at 0 and no further pulse comes, whatever ticks arrive, until 0xF6 or 0x30 is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe, one cycle per access |
| portSel | input | 1 | 0 selects the index location, 1 the data location |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Data-location read value for the current index |
| tickEn | input | 1 | One-cycle time-base strobe (one per second) |
| kbdIrq | input | 1 | Keyboard interrupt level |
| mouseIrq | input | 1 | Mouse interrupt level |
| wdtRst | output | 1 | Watchdog reset pulse |

## Verification
An unlock state machine stuck in the wrong state shows at once. The next data read returns 0xFF where a register value is expected, or a register value where 0xFF is expected, and a data write lands or vanishes against the model. A wrong page or index register is caught on the read that follows the write that set it. A fault in the countdown or prescaler shows on the first `tickEn` after the timer is loaded, as a read-back count that is off by one unit. A fault in the expiry path shows as a pulse that starts a cycle late, has the wrong length, or repeats after the halt.

// File: rtl/wdt_cfg_pkg.sv
package wdt_cfg_pkg;
  localparam int DW = 8;

  localparam logic [DW-1:0] KEY_OPEN  = 8'h87;
  localparam logic [DW-1:0] KEY_CLOSE = 8'hAA;
  localparam logic [DW-1:0] IDX_PAGE  = 8'h07;
  localparam logic [DW-1:0] PAGE_WDT  = 8'h08;
  localparam logic [DW-1:0] IDX_EN    = 8'h30;
  localparam logic [DW-1:0] IDX_UNIT  = 8'hF5;
  localparam logic [DW-1:0] IDX_TIMER = 8'hF6;
  localparam logic [DW-1:0] IDX_SRC   = 8'hF7;

  typedef enum logic [1:0] {LK_CLOSED, LK_HALF, LK_OPEN} lockSt_t;
  typedef enum logic [2:0] {RS_NONE, RS_EN, RS_UNIT, RS_TIMER, RS_SRC} rdSel_t;

  typedef struct packed {
    logic           enWr;
    logic           unitWr;
    logic           timerWr;
    logic           srcWr;
    logic [DW-1:0]  data;
    rdSel_t         rdSel;
  } dpCmd_t;
endpackage

// File: rtl/wdt_cfg_ctrl.sv
module wdt_cfg_ctrl
  import wdt_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          portSel,
  input  logic [DW-1:0] wrData,
  output dpCmd_t        cmd,
  output logic          pageRd,
  output logic [DW-1:0] pageVal
);
  lockSt_t       state;
  logic [DW-1:0] idx;
  logic [DW-1:0] page;
  logic          idxWr, dataWr, isOpen, onPage;

  assign idxWr  = wrEn & ~portSel;
  assign dataWr = wrEn & portSel;
  assign isOpen = (state == LK_OPEN);
  assign onPage = isOpen && (page == PAGE_WDT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= LK_CLOSED;
      idx   <= '0;
      page  <= '0;
    end else begin
      if (idxWr) begin
        case (state)
          LK_CLOSED: state <= (wrData == KEY_OPEN) ? LK_HALF : LK_CLOSED;
          LK_HALF:   state <= (wrData == KEY_OPEN) ? LK_OPEN : LK_CLOSED;
          LK_OPEN: begin
            if (wrData == KEY_CLOSE) state <= LK_CLOSED;
            else                     idx   <= wrData;
          end
          default:   state <= LK_CLOSED;
        endcase
      end
      if (dataWr && isOpen && idx == IDX_PAGE) page <= wrData;
    end
  end

  always_comb begin
    cmd         = '0;
    cmd.data    = wrData;
    cmd.rdSel   = RS_NONE;
    if (onPage) begin
      case (idx)
        IDX_EN:    begin cmd.rdSel = RS_EN;    cmd.enWr    = dataWr; end
        IDX_UNIT:  begin cmd.rdSel = RS_UNIT;  cmd.unitWr  = dataWr; end
        IDX_TIMER: begin cmd.rdSel = RS_TIMER; cmd.timerWr = dataWr; end
        IDX_SRC:   begin cmd.rdSel = RS_SRC;   cmd.srcWr   = dataWr; end
        default:   cmd.rdSel = RS_NONE;
      endcase
    end
  end

  assign pageRd  = isOpen && (idx == IDX_PAGE);
  assign pageVal = page;

  // R3
  close_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idxWr && isOpen && wrData == KEY_CLOSE) |=> (state == LK_CLOSED));

  // R2
  stay_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == LK_CLOSED && !(idxWr && wrData == KEY_OPEN)) |=> (state == LK_CLOSED));

  // R2
  closed_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != LK_OPEN) |-> !(cmd.enWr || cmd.unitWr || cmd.timerWr || cmd.srcWr));
endmodule

// File: rtl/wdt_cfg_dp.sv
module wdt_cfg_dp
  import wdt_cfg_pkg::*;
#(
  parameter int MIN_TICKS = 60,
  parameter int RST_PULSE = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCmd_t        cmd,
  input  logic          tickEn,
  input  logic          kbdIrq,
  input  logic          mouseIrq,
  output logic [DW-1:0] dpRd,
  output logic          wdtRst
);
  localparam int PRE_W = $clog2(MIN_TICKS + 1);
  localparam int RST_W = $clog2(RST_PULSE + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MIN_TICKS - 1);
  localparam logic [RST_W-1:0] RST_LEN  = RST_W'(RST_PULSE);

  logic             runEn, minMode, kbEn, msEn, tripped;
  logic [DW-1:0]    count, reloadVal;
  logic [PRE_W-1:0] pre;
  logic [RST_W-1:0] rstCnt;
  logic             armed, irqHit, blocked, stepOk, unitStep, fire;

  assign armed    = runEn & ~tripped;
  assign irqHit   = armed & ((kbEn & kbdIrq) | (msEn & mouseIrq));
  assign blocked  = cmd.timerWr | cmd.enWr | cmd.unitWr | irqHit;
  assign stepOk   = armed & tickEn & ~blocked;
  assign unitStep = stepOk & (~minMode | (pre == PRE_LAST));
  assign fire     = unitStep & (count <= 8'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn     <= 1'b0;
      minMode   <= 1'b0;
      kbEn      <= 1'b0;
      msEn      <= 1'b0;
      tripped   <= 1'b0;
      count     <= '0;
      reloadVal <= '0;
      pre       <= '0;
      rstCnt    <= '0;
    end else begin
      if (cmd.enWr) begin
        runEn   <= cmd.data[0];
        tripped <= 1'b0;
      end
      if (cmd.unitWr) begin
        minMode <= cmd.data[3];
        pre     <= '0;
      end
      if (cmd.srcWr) begin
        kbEn <= cmd.data[6];
        msEn <= cmd.data[7];
      end
      if (cmd.timerWr) begin
        count     <= cmd.data;
        reloadVal <= cmd.data;
        tripped   <= 1'b0;
        pre       <= '0;
      end else if (irqHit) begin
        count <= reloadVal;
        pre   <= '0;
      end else if (stepOk) begin
        if (unitStep) begin
          pre <= '0;
          if (fire) begin
            count   <= '0;
            tripped <= 1'b1;
          end else begin
            count <= count - 8'd1;
          end
        end else begin
          pre <= pre + 1'b1;
        end
      end
      if (fire)             rstCnt <= RST_LEN;
      else if (rstCnt != 0) rstCnt <= rstCnt - 1'b1;
    end
  end

  assign wdtRst = (rstCnt != 0);

  always_comb begin
    case (cmd.rdSel)
      RS_EN:    dpRd = {7'b0, runEn};
      RS_UNIT:  dpRd = {4'b0, minMode, 3'b0};
      RS_TIMER: dpRd = count;
      RS_SRC:   dpRd = {msEn, kbEn, 6'b0};
      default:  dpRd = 8'hFF;
    endcase
  end

  // R9
  expiry_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> (wdtRst && tripped && count == 8'd0));

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tripped && !cmd.timerWr && !cmd.enWr) |=> ($stable(count) && tripped));

  // R6
  timer_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.timerWr |=> (count == $past(cmd.data)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !cmd.timerWr) |=> $stable(count));
endmodule

// File: rtl/wdt_cfg_port.sv
module wdt_cfg_port
  import wdt_cfg_pkg::*;
#(
  parameter int MIN_TICKS = 60,
  parameter int RST_PULSE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       portSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       tickEn,
  input  logic       kbdIrq,
  input  logic       mouseIrq,
  output logic       wdtRst
);
  dpCmd_t        cmd;
  logic          pageRd;
  logic [DW-1:0] pageVal, dpRd;

  wdt_cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .portSel(portSel), .wrData(wrData),
    .cmd(cmd), .pageRd(pageRd), .pageVal(pageVal)
  );

  wdt_cfg_dp #(.MIN_TICKS(MIN_TICKS), .RST_PULSE(RST_PULSE)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .tickEn(tickEn), .kbdIrq(kbdIrq),
    .mouseIrq(mouseIrq), .dpRd(dpRd), .wdtRst(wdtRst)
  );

  assign rdData = pageRd ? pageVal : dpRd;
endmodule

// File: tb/wdt_cfg_port_bench.sv
module wdt_cfg_port_bench;
  localparam int MT = 3;
  localparam int RP = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       portSel = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       tickEn = 1'b0;
  logic       kbdIrq = 1'b0;
  logic       mouseIrq = 1'b0;
  logic       wdtRst;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model of the register space (no timing)
  int         mSt = 0;
  logic [7:0] mIdx = '0, mPage = '0, mTmr = '0;
  logic       mEn = 0, mUnit = 0, mKb = 0, mMs = 0;

  wdt_cfg_port #(.MIN_TICKS(MT), .RST_PULSE(RP)) u_wdt_cfg_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .portSel(portSel), .wrData(wrData),
    .rdData(rdData), .tickEn(tickEn), .kbdIrq(kbdIrq), .mouseIrq(mouseIrq),
    .wdtRst(wdtRst)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] expRd();
    if (mSt != 2) return 8'hFF;
    if (mIdx == 8'h07) return mPage;
    if (mPage != 8'h08) return 8'hFF;
    case (mIdx)
      8'h30:   return {7'b0, mEn};
      8'hF5:   return {4'b0, mUnit, 3'b0};
      8'hF6:   return mTmr;
      8'hF7:   return {mMs, mKb, 6'b0};
      default: return 8'hFF;
    endcase
  endfunction

  function automatic void mdlApply(input logic p, input logic [7:0] d);
    if (!p) begin
      case (mSt)
        0: mSt = (d == 8'h87) ? 1 : 0;
        1: mSt = (d == 8'h87) ? 2 : 0;
        default: if (d == 8'hAA) mSt = 0; else mIdx = d;
      endcase
    end else if (mSt == 2) begin
      if (mIdx == 8'h07) mPage = d;
      else if (mPage == 8'h08) begin
        case (mIdx)
          8'h30: mEn = d[0];
          8'hF5: mUnit = d[3];
          8'hF6: mTmr = d;
          8'hF7: begin mKb = d[6]; mMs = d[7]; end
          default: ;
        endcase
      end
    end
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic p, input logic [7:0] d);
    @(negedge clk);
    portSel = p; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    mdlApply(p, d);
  endtask

  task automatic tick();
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
  endtask

  task automatic pulseIrq(input logic kb, input logic ms);
    @(negedge clk); kbdIrq = kb; mouseIrq = ms;
    @(negedge clk); kbdIrq = 1'b0; mouseIrq = 1'b0;
  endtask

  task automatic unlock();
    wr(0, 8'h87); wr(0, 8'h87);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] pool [9];
    int hi;
    pool = '{8'h87, 8'hAA, 8'h07, 8'h08, 8'h30, 8'hF5, 8'hF6, 8'hF7, 8'h00};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 read", rdData, 8'hFF);
    chk("R1 rst", {7'b0, wdtRst}, 8'h00);

    // R2: interrupted key sequence stays closed
    wr(0, 8'h87); wr(0, 8'h55); wr(0, 8'h87); wr(0, 8'h07);
    chk("R2 broken key", rdData, 8'hFF);
    wr(1, 8'h08);
    chk("R2 closed write", rdData, 8'hFF);

    // random register-space traffic, no time base
    for (int i = 0; i < 400; i++) begin
      logic p;
      logic [7:0] d;
      p = 1'($urandom_range(0, 1));
      d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : pool[$urandom_range(0, 8)];
      wr(p, d);
      chk((mSt != 2) ? "R2 random" : "R4 random", rdData, expRd());
    end

    // directed
    wr(0, 8'hAA);
    unlock();
    wr(0, 8'h07); wr(1, 8'h08);
    chk("R4 page readback", rdData, 8'h08);
    wr(0, 8'h30); wr(1, 8'h00);
    wr(0, 8'hF5); wr(1, 8'h00);
    chk("R7 unit read", rdData, 8'h00);
    wr(0, 8'hF7); wr(1, 8'h00);
    wr(0, 8'hF6); wr(1, 8'h03);
    chk("R6 timer load", rdData, 8'h03);
    tick(); tick();
    chk("R5 disabled hold", rdData, 8'h03);
    wr(0, 8'h30); wr(1, 8'hFF);
    chk("R5 enable read", rdData, 8'h01);
    wr(0, 8'hF6);
    tick();
    chk("R7 seconds step", rdData, 8'h02);
    tick();
    chk("R7 seconds step", rdData, 8'h01);
    chk("R9 no early rst", {7'b0, wdtRst}, 8'h00);
    tick();
    hi = 0;
    for (int k = 0; k < RP + 4; k++) begin
      if (wdtRst) hi++;
      @(negedge clk);
    end
    chk("R9 pulse length", 8'(hi), 8'(RP));
    chk("R9 count zero", rdData, 8'h00);
    tick(); tick(); tick();
    chk("R10 halted count", rdData, 8'h00);
    chk("R10 no repulse", {7'b0, wdtRst}, 8'h00);

    // minutes mode
    wr(0, 8'hF5); wr(1, 8'h08);
    chk("R7 unit bit3", rdData, 8'h08);
    wr(0, 8'hF6); wr(1, 8'h02);
    tick(); tick();
    chk("R7 minute hold", rdData, 8'h02);
    tick();
    chk("R7 minute step", rdData, 8'h01);

    // interrupt reload
    wr(0, 8'hF5); wr(1, 8'h00);
    wr(0, 8'hF7); wr(1, 8'h40);
    chk("R8 src read", rdData, 8'h40);
    wr(0, 8'hF6); wr(1, 8'h05);
    tick(); tick();
    chk("R8 before irq", rdData, 8'h03);
    pulseIrq(0, 1);
    chk("R8 mouse masked", rdData, 8'h03);
    pulseIrq(1, 0);
    chk("R8 kbd reload", rdData, 8'h05);

    // foreign page
    wr(0, 8'h07); wr(1, 8'h05);
    wr(0, 8'hF6);
    chk("R4 foreign page read", rdData, 8'hFF);
    wr(1, 8'h09);
    wr(0, 8'h07); wr(1, 8'h08);
    wr(0, 8'hF6);
    chk("R4 foreign page write", rdData, 8'h05);
    wr(0, 8'h42);
    chk("R4 unused index", rdData, 8'hFF);
    wr(0, 8'hF6);

    // relock
    wr(0, 8'hAA);
    chk("R3 closed read", rdData, 8'hFF);
    wr(1, 8'h11);
    unlock();
    chk("R3 closed write dropped", rdData, 8'h05);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule